// File: doc/BRIEF.md
# Masked SIMD Processing-Element Array

A 4x4 mesh of small ALU-style processing elements that all execute one broadcast instruction in the same clock cycle, each on its own data. Every element holds four 16-bit general registers, a private 16-word local memory, a condition flag, a one-bit disable mask and a one-deep copy of the mask. Elements whose mask is set skip data instructions. This lets a controller run a parallel if-then-else. First, a compare sets each element's condition flag. IF then disables the elements whose condition is false. ELSE swaps which of the elements that were enabled on entry take part. ENDIF brings back the mask that was in force on entry.

Instructions arrive on one broadcast port with a valid/ready handshake and complete in one cycle. A neighbour shift copies one register from every element to its mesh neighbour in a single direction. A host port preloads and reads back the local memories. It picks an element by index (row times four plus column, with row 0 on the north edge and column 0 on the west edge). A host request stalls the instruction port, so host and array never touch memory in the same cycle.

Top module: `simd_pe_array`

## Requirements
- R1: ADD (op 3) writes rs+rt and SUB (op 4) writes rs-rt, modulo 2^16, into register rd of every enabled element. The result is written on the edge that accepts the instruction.
- R2: LOAD (op 1) copies local word addr into rd, and STORE (op 2) writes rs into local word addr. Every element uses the same addr from the instruction, and no other word changes.
- R3: An element with its mask set leaves its registers, condition flag and memory unchanged on every data instruction (ops 1 to 6 and 10).
- R4: CMPLT (op 5) sets the condition flag to rs<rt (unsigned) and CMPEQ (op 6) sets it to rs==rt, in enabled elements only. IF (op 7) copies every mask into the saved mask and then sets the mask of each enabled element whose condition is false. An element that is already disabled stays disabled.
- R5: ELSE (op 8) inverts the mask only in elements whose saved mask is clear. Elements that were disabled before the IF stay disabled.
- R6: ENDIF (op 9) copies the saved mask back into the mask of every element.
- R7: SHIFT (op 10) sends register rs of every element one step in the direction dir (0 north, 1 south, 2 east, 3 west), where it lands in register rd. An element with no neighbour on the sending side receives zero. A receiver latches the value when it is enabled, even if the sender is disabled.
- R8: instr_ready_o is low while host_req_i is high. An instruction executes only on a cycle where instr_valid_i and instr_ready_o are both high.
- R9: A host write (host_req_i and host_we_i) stores host_wdata_i into word host_addr_i of element host_pe_i. A host read returns that word on host_rdata_o from the edge after the request.
- R10: Reset clears every register, local memory word, condition flag and mask, so all elements come out of reset enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Broadcast instruction present |
| instr_ready_o | output | 1 | Array can accept an instruction |
| instr_op_i | input | 4 | Operation code |
| instr_rd_i | input | 2 | Destination register |
| instr_rs_i | input | 2 | First source register |
| instr_rt_i | input | 2 | Second source register |
| instr_addr_i | input | 4 | Common local memory address |
| instr_dir_i | input | 2 | Shift direction |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | Host write when high, read when low |
| host_pe_i | input | 4 | Element index, row*4+column |
| host_addr_i | input | 4 | Local word address for host access |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, registered |

## Verification
A host access and a broadcast instruction can both be requested in the same cycle, and both may aim at the same local word. The bench raises a host write and a STORE to that word together. It checks that ready is low while the host request is present and rises once the request drops. It then reads back the word and expects the register value stored by the instruction, which can only be there if the host write went first and the instruction was held for one cycle.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_CMPLT = 4'd5,
    OP_CMPEQ = 4'd6,
    OP_IF    = 4'd7,
    OP_ELSE  = 4'd8,
    OP_ENDIF = 4'd9,
    OP_SHIFT = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_S = 2'd1,
    DIR_E = 2'd2,
    DIR_W = 2'd3
  } dir_e;
endpackage

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MEM_DEPTH = 16,
  parameter int unsigned NREG      = 4,
  localparam int unsigned AW = $clog2(MEM_DEPTH),
  localparam int unsigned RW = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  op_e               op_i,
  input  logic [RW-1:0]     rd_i,
  input  logic [RW-1:0]     rs_i,
  input  logic [RW-1:0]     rt_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] link_i,
  output logic [DATA_W-1:0] link_o,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              mask_o,
  output logic              save_o
);
  logic [DATA_W-1:0] regs_q [NREG];
  logic [DATA_W-1:0] mem_q  [MEM_DEPTH];
  logic mask_q, save_q, cond_q;
  logic active;
  logic [DATA_W-1:0] op_a, op_b;

  assign active       = fire_i & ~mask_q;
  assign op_a         = regs_q[rs_i];
  assign op_b         = regs_q[rt_i];
  assign link_o       = op_a;
  assign host_rdata_o = mem_q[host_addr_i];
  assign mask_o       = mask_q;
  assign save_o       = save_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (active) begin
      unique case (op_i)
        OP_LOAD:  regs_q[rd_i] <= mem_q[addr_i];
        OP_ADD:   regs_q[rd_i] <= op_a + op_b;
        OP_SUB:   regs_q[rd_i] <= op_a - op_b;
        OP_SHIFT: regs_q[rd_i] <= link_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
    end else if (host_we_i) begin
      mem_q[host_addr_i] <= host_wdata_i;
    end else if (active && op_i == OP_STORE) begin
      mem_q[addr_i] <= op_a;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
    end else if (active) begin
      if (op_i == OP_CMPLT) cond_q <= op_a < op_b;
      else if (op_i == OP_CMPEQ) cond_q <= op_a == op_b;
    end
  end

  // mask control runs in every element, enabled or not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b0;
      save_q <= 1'b0;
    end else if (fire_i) begin
      unique case (op_i)
        OP_IF: begin
          save_q <= mask_q;
          if (!mask_q) mask_q <= ~cond_q;
        end
        OP_ELSE:  if (!save_q) mask_q <= ~mask_q;
        OP_ENDIF: mask_q <= save_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/simd_link_mux.sv
module simd_link_mux
  import simd_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter bit HAS_N = 1'b1,
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_W = 1'b1,
  parameter bit HAS_E = 1'b1
) (
  input  dir_e              dir_i,
  input  logic [DATA_W-1:0] from_n_i,
  input  logic [DATA_W-1:0] from_s_i,
  input  logic [DATA_W-1:0] from_w_i,
  input  logic [DATA_W-1:0] from_e_i,
  output logic [DATA_W-1:0] link_o
);
  logic [DATA_W-1:0] n_v, s_v, w_v, e_v;

  assign n_v = HAS_N ? from_n_i : '0;
  assign s_v = HAS_S ? from_s_i : '0;
  assign w_v = HAS_W ? from_w_i : '0;
  assign e_v = HAS_E ? from_e_i : '0;

  // data moving in a direction arrives from the opposite side
  always_comb begin
    unique case (dir_i)
      DIR_N:   link_o = s_v;
      DIR_S:   link_o = n_v;
      DIR_E:   link_o = w_v;
      default: link_o = e_v;
    endcase
  end
endmodule

// File: rtl/simd_host_port.sv
module simd_host_port #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NPE    = 16,
  localparam int unsigned PW = $clog2(NPE)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [PW-1:0]           pe_i,
  input  logic [NPE*DATA_W-1:0]   pe_rdata_i,
  output logic [NPE-1:0]          pe_we_o,
  output logic [DATA_W-1:0]       rdata_o
);
  for (genvar i = 0; i < NPE; i++) begin : g_we
    assign pe_we_o[i] = req_i & we_i & (pe_i == PW'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= pe_rdata_i[pe_i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MEM_DEPTH = 16,
  parameter int unsigned NREG      = 4,
  parameter int unsigned ROWS      = 4,
  parameter int unsigned COLS      = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                instr_valid_i,
  output logic                                instr_ready_o,
  input  logic [3:0]                          instr_op_i,
  input  logic [$clog2(NREG)-1:0]             instr_rd_i,
  input  logic [$clog2(NREG)-1:0]             instr_rs_i,
  input  logic [$clog2(NREG)-1:0]             instr_rt_i,
  input  logic [$clog2(MEM_DEPTH)-1:0]        instr_addr_i,
  input  logic [1:0]                          instr_dir_i,
  input  logic                                host_req_i,
  input  logic                                host_we_i,
  input  logic [$clog2(ROWS*COLS)-1:0]        host_pe_i,
  input  logic [$clog2(MEM_DEPTH)-1:0]        host_addr_i,
  input  logic [DATA_W-1:0]                   host_wdata_i,
  output logic [DATA_W-1:0]                   host_rdata_o
);
  localparam int unsigned NPE = ROWS * COLS;

  logic fire;
  op_e  op;
  dir_e dir;
  logic [DATA_W-1:0]     link_out [NPE];
  logic [DATA_W-1:0]     link_in  [NPE];
  logic [NPE*DATA_W-1:0] pe_rdata;
  logic [NPE-1:0]        pe_hwe, pe_mask, pe_save;

  assign instr_ready_o = ~host_req_i;
  assign fire          = instr_valid_i & instr_ready_o;
  assign op            = op_e'(instr_op_i);
  assign dir           = dir_e'(instr_dir_i);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int unsigned IDX = r * COLS + c;
      localparam bit HN = (r > 0);
      localparam bit HS = (r < ROWS - 1);
      localparam bit HW = (c > 0);
      localparam bit HE = (c < COLS - 1);
      localparam int unsigned IN = HN ? IDX - COLS : IDX;
      localparam int unsigned IS = HS ? IDX + COLS : IDX;
      localparam int unsigned IW = HW ? IDX - 1 : IDX;
      localparam int unsigned IE = HE ? IDX + 1 : IDX;

      simd_link_mux #(
        .DATA_W(DATA_W), .HAS_N(HN), .HAS_S(HS), .HAS_W(HW), .HAS_E(HE)
      ) u_link (
        .dir_i   (dir),
        .from_n_i(link_out[IN]),
        .from_s_i(link_out[IS]),
        .from_w_i(link_out[IW]),
        .from_e_i(link_out[IE]),
        .link_o  (link_in[IDX])
      );

      simd_pe #(
        .DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH), .NREG(NREG)
      ) u_pe (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fire_i      (fire),
        .op_i        (op),
        .rd_i        (instr_rd_i),
        .rs_i        (instr_rs_i),
        .rt_i        (instr_rt_i),
        .addr_i      (instr_addr_i),
        .link_i      (link_in[IDX]),
        .link_o      (link_out[IDX]),
        .host_we_i   (pe_hwe[IDX]),
        .host_addr_i (host_addr_i),
        .host_wdata_i(host_wdata_i),
        .host_rdata_o(pe_rdata[IDX*DATA_W +: DATA_W]),
        .mask_o      (pe_mask[IDX]),
        .save_o      (pe_save[IDX])
      );
    end
  end

  simd_host_port #(.DATA_W(DATA_W), .NPE(NPE)) u_host (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (host_req_i),
    .we_i      (host_we_i),
    .pe_i      (host_pe_i),
    .pe_rdata_i(pe_rdata),
    .pe_we_o   (pe_hwe),
    .rdata_o   (host_rdata_o)
  );
endmodule

// File: rtl/simd_pe_array_chk.sv
module simd_pe_array_chk #(
  parameter int unsigned NPE = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           host_req_i,
  input logic           instr_ready_o,
  input logic           fire_i,
  input logic [3:0]     op_i,
  input logic [NPE-1:0] mask_i,
  input logic [NPE-1:0] save_i
);
  a_r8_host_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i |-> !instr_ready_o);

  a_r3_idle_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> ($stable(mask_i) && $stable(save_i)));

  a_r3_data_op_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && op_i != 4'd7 && op_i != 4'd8 && op_i != 4'd9) |=> $stable(mask_i));

  a_r4_if_keeps_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && op_i == 4'd7) |=> ((($past(mask_i) & ~mask_i) == '0) && save_i == $past(mask_i)));

  a_r5_else_keeps_prior: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && op_i == 4'd8) |=> ((mask_i & $past(save_i)) == $past(save_i)));

  a_r6_endif_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && op_i == 4'd9) |=> (mask_i == $past(save_i)));
endmodule

bind simd_pe_array simd_pe_array_chk #(.NPE(ROWS*COLS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_req_i   (host_req_i),
  .instr_ready_o(instr_ready_o),
  .fire_i       (fire),
  .op_i         (instr_op_i),
  .mask_i       (pe_mask),
  .save_i       (pe_save)
);

// File: tb/simd_pe_array_bench.sv
module simd_pe_array_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic instr_ready;
  logic [3:0] op = '0;
  logic [1:0] rd = '0, rs = '0, rt = '0, dir = '0;
  logic [3:0] addr = '0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [3:0] host_pe = '0, host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  simd_pe_array u_simd_pe_array (
    .clk_i(clk), .rst_ni(rst_n),
    .instr_valid_i(instr_valid), .instr_ready_o(instr_ready),
    .instr_op_i(op), .instr_rd_i(rd), .instr_rs_i(rs), .instr_rt_i(rt),
    .instr_addr_i(addr), .instr_dir_i(dir),
    .host_req_i(host_req), .host_we_i(host_we), .host_pe_i(host_pe),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata)
  );

  // rows: {a, b}; element i gets a+i and b
  localparam logic [31:0] VEC [4] = '{
    {16'h0001, 16'h0002},
    {16'hFFFF, 16'h0001},
    {16'h8000, 16'h8000},
    {16'h0010, 16'h0030}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic host_wr(input int pe, input int a, input logic [15:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1;
    host_pe = pe[3:0]; host_addr = a[3:0]; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input int pe, input int a, output logic [15:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0;
    host_pe = pe[3:0]; host_addr = a[3:0];
    @(negedge clk);
    host_req = 1'b0;
    d = host_rdata;
  endtask

  task automatic issue(input logic [3:0] o, input logic [1:0] d_r, input logic [1:0] s_r,
                       input logic [1:0] t_r, input logic [3:0] a, input logic [1:0] dr);
    @(negedge clk);
    instr_valid = 1'b1;
    op = o; rd = d_r; rs = s_r; rt = t_r; addr = a; dir = dr;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    do_reset();

    // R10: memory and registers clear, every element enabled
    host_rd(5, 3, v);
    chk("R10 mem clear", v, 16'h0000);
    host_wr(11, 4, 16'h0777);
    issue(4'd2, 2'd0, 2'd2, 2'd0, 4'd4, 2'd0);
    host_rd(11, 4, v);
    chk("R10 reg clear and enabled", v, 16'h0000);

    // R8: host write and STORE collide on the same word
    host_wr(0, 0, 16'h1234);
    issue(4'd1, 2'd0, 2'd0, 2'd0, 4'd0, 2'd0);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_pe = 4'd0; host_addr = 4'd9; host_wdata = 16'h0055;
    instr_valid = 1'b1; op = 4'd2; rs = 2'd0; addr = 4'd9;
    #1 chk("R8 ready low on host req", {15'd0, instr_ready}, 16'h0000);
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    #1 chk("R8 ready back", {15'd0, instr_ready}, 16'h0001);
    @(negedge clk);
    instr_valid = 1'b0;
    host_rd(0, 9, v);
    chk("R8 store after host write", v, 16'h1234);

    // R1 R2 R9: table of operand patterns
    foreach (VEC[k]) begin
      logic [15:0] a_v, b_v;
      a_v = VEC[k][31:16];
      b_v = VEC[k][15:0];
      for (int p = 0; p < 16; p++) begin
        host_wr(p, 0, a_v + 16'(p));
        host_wr(p, 1, b_v);
      end
      issue(4'd1, 2'd0, 2'd0, 2'd0, 4'd0, 2'd0);
      issue(4'd1, 2'd1, 2'd0, 2'd0, 4'd1, 2'd0);
      issue(4'd3, 2'd2, 2'd0, 2'd1, 4'd0, 2'd0);
      issue(4'd4, 2'd3, 2'd0, 2'd1, 4'd0, 2'd0);
      issue(4'd2, 2'd0, 2'd2, 2'd0, 4'd2, 2'd0);
      issue(4'd2, 2'd0, 2'd3, 2'd0, 4'd3, 2'd0);
      for (int p = 0; p < 16; p += 15) begin
        host_rd(p, 2, v);
        chk("R1 add", v, a_v + 16'(p) + b_v);
        host_rd(p, 3, v);
        chk("R1 sub", v, a_v + 16'(p) - b_v);
      end
      host_rd(9, 7, v);
      chk("R2 untouched word", v, 16'h0000);
      host_rd(6, 1, v);
      chk("R9 host readback", v, b_v);
    end

    // R4 R5 R6 R3: masked if-then-else with elements disabled beforehand
    do_reset();
    for (int p = 0; p < 16; p++) begin
      host_wr(p, 0, 16'(p));
      host_wr(p, 1, 16'd8);
      host_wr(p, 2, 16'(p & 1));
    end
    issue(4'd1, 2'd0, 2'd0, 2'd0, 4'd0, 2'd0);
    issue(4'd1, 2'd1, 2'd0, 2'd0, 4'd1, 2'd0);
    issue(4'd1, 2'd2, 2'd0, 2'd0, 4'd2, 2'd0);
    issue(4'd1, 2'd3, 2'd0, 2'd0, 4'd3, 2'd0);
    issue(4'd5, 2'd0, 2'd0, 2'd1, 4'd0, 2'd0); // p < 8
    issue(4'd7, 2'd0, 2'd0, 2'd0, 4'd0, 2'd0);
    issue(4'd6, 2'd0, 2'd2, 2'd3, 4'd0, 2'd0); // even
    issue(4'd7, 2'd0, 2'd0, 2'd0, 4'd0, 2'd0);
    issue(4'd3, 2'd0, 2'd0, 2'd1, 4'd0, 2'd0);
    issue(4'd2, 2'd0, 2'd0, 2'd0, 4'd4, 2'd0);
    issue(4'd8, 2'd0, 2'd0, 2'd0, 4'd0, 2'd0);
    issue(4'd4, 2'd0, 2'd0, 2'd1, 4'd0, 2'd0);
    issue(4'd2, 2'd0, 2'd0, 2'd0, 4'd5, 2'd0);
    issue(4'd9, 2'd0, 2'd0, 2'd0, 4'd0, 2'd0);
    issue(4'd2, 2'd0, 2'd1, 2'd0, 4'd6, 2'd0);
    host_rd(2, 4, v);  chk("R4 then on even low", v, 16'd10);
    host_rd(3, 4, v);  chk("R4 then skips odd", v, 16'd0);
    host_rd(10, 4, v); chk("R3 disabled skips then", v, 16'd0);
    host_rd(3, 5, v);  chk("R5 else on odd low", v, 16'hFFFB);
    host_rd(2, 5, v);  chk("R5 else skips then side", v, 16'd0);
    host_rd(9, 5, v);  chk("R5 prior disabled stays", v, 16'd0);
    host_rd(5, 6, v);  chk("R6 endif restores low", v, 16'd8);
    host_rd(12, 6, v); chk("R6 endif keeps high off", v, 16'd0);

    // R7: neighbour shifts in all four directions, edge zero
    do_reset();
    for (int p = 0; p < 16; p++) begin
      host_wr(p, 0, 16'(100 + p));
      host_wr(p, 5, 16'd105);
    end
    issue(4'd1, 2'd0, 2'd0, 2'd0, 4'd0, 2'd0);
    issue(4'd10, 2'd1, 2'd0, 2'd0, 4'd0, 2'd2);
    issue(4'd2, 2'd0, 2'd1, 2'd0, 4'd1, 2'd0);
    issue(4'd10, 2'd1, 2'd0, 2'd0, 4'd0, 2'd0);
    issue(4'd2, 2'd0, 2'd1, 2'd0, 4'd2, 2'd0);
    issue(4'd10, 2'd1, 2'd0, 2'd0, 4'd0, 2'd1);
    issue(4'd2, 2'd0, 2'd1, 2'd0, 4'd3, 2'd0);
    issue(4'd10, 2'd1, 2'd0, 2'd0, 4'd0, 2'd3);
    issue(4'd2, 2'd0, 2'd1, 2'd0, 4'd4, 2'd0);
    host_rd(5, 1, v);  chk("R7 east", v, 16'd104);
    host_rd(4, 1, v);  chk("R7 east edge zero", v, 16'd0);
    host_rd(1, 2, v);  chk("R7 north", v, 16'd105);
    host_rd(13, 2, v); chk("R7 north edge zero", v, 16'd0);
    host_rd(6, 3, v);  chk("R7 south", v, 16'd102);
    host_rd(2, 3, v);  chk("R7 south edge zero", v, 16'd0);
    host_rd(6, 4, v);  chk("R7 west", v, 16'd107);
    host_rd(7, 4, v);  chk("R7 west edge zero", v, 16'd0);

    // R7 R3: only element 5 enabled, its sender is disabled
    issue(4'd1, 2'd3, 2'd0, 2'd0, 4'd5, 2'd0);
    issue(4'd6, 2'd0, 2'd0, 2'd3, 4'd0, 2'd0);
    issue(4'd7, 2'd0, 2'd0, 2'd0, 4'd0, 2'd0);
    issue(4'd10, 2'd3, 2'd0, 2'd0, 4'd0, 2'd2);
    issue(4'd2, 2'd0, 2'd3, 2'd0, 4'd6, 2'd0);
    host_rd(5, 6, v);  chk("R7 receive from disabled sender", v, 16'd104);
    host_rd(6, 6, v);  chk("R3 disabled store skipped", v, 16'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule